// File: doc/BRIEF.md
# Indirect Ethernet Controller Register File

This block is the host-facing register set of a simple Ethernet controller. The host sees only two 16-bit word ports. Offset 0 is the data port and offset 1 is the address port. A write to the address port picks one of four internal registers. A read or write of the data port then reaches the register that was picked. Register 0 is the main control/status word. It holds the start, initialize and stop commands, the receiver-on and transmitter-on flags, sticky event flags that are cleared by writing 1, the interrupt enable, and two summary bits that the block derives itself. Registers 1 and 2 are the low and high halves of a 32-bit initialization-block pointer. Register 3 holds three bus-mode bits.

The receive and transmit ring engines sit outside this block. Each one pulses a single event input when it finishes a frame, and the block records that event in the status word. The interrupt line is high while the derived interrupt summary bit and the enable bit are both set.

The bus is a plain register interface with no back-pressure. Every access is taken in the cycle in which `bus_en` is high. Writes take effect at that clock edge. Read data is combinational from the selected port and the current register state.

Top module: `enet_regfile`

## Requirements
- R1: After reset, register 0 reads 0x0004 (only the STOP bit, bit 2, is set), the selected register number is 0, the init pointer and the mode bits are 0, and `irq` is low.
- R2: A write to the address port (`bus_port`=1) changes the selected register only when the written 16-bit value is below 4. Any other value is ignored. A read of the address port returns the selected number in bits 1:0, and bits 15:2 read 0.
- R3: A data-port write to register 0 with bit 2 set leaves register 0 at exactly 0x0004. All other bits of that write are ignored, and so is a same-cycle event input.
- R4: In register 0, bits 14:8 are cleared by writing 1 to them and are not changed by writing 0.
- R5: Bit 15 of register 0 always equals the OR of bits 14:11. Bit 7 always equals the OR of bits 14:8. Written values of bits 15, 7 and 3 have no effect (bit 3 reads 0).
- R6: Bit 6 (interrupt enable) takes the written bit 6 on every write to register 0 that does not set bit 2.
- R7: A write to register 0 with bit 0 set sets bit 0 and bit 8 and clears bit 2. Otherwise, a write with bit 1 set sets bits 1, 5 and 4 and clears bit 2. When bits 0 and 1 are both written, only the bit-0 action happens.
- R8: A one-cycle pulse on `rx_done` sets bit 10, and a pulse on `tx_done` sets bit 9. Each raises bit 7 as well. An event wins over a write-one-to-clear of its bit in the same cycle.
- R9: `irq` is high exactly when bits 7 and 6 of register 0 are both set.
- R10: Register 1 holds `init_ptr[15:0]` and register 2 holds `init_ptr[31:16]`. Both read back in full. Register 3 keeps written bits 2:0, drives them on `bus_mode`, and reads 0 in bits 15:3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_port | input | 1 | Word offset: 0 data port, 1 address port |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed port |
| rx_done | input | 1 | Receive-complete event pulse |
| tx_done | input | 1 | Transmit-complete event pulse |
| irq | output | 1 | Interrupt request |
| init_ptr | output | 32 | Initialization-block pointer |
| bus_mode | output | 3 | Bus-mode bits |

## Verification
The bench writes both command bits together and checks that only the initialize action happens. A design that let start win, or ran both actions, would show bits 1, 5 and 4 set. It writes the stop bit together with every other bit, and also during an event pulse. A design that merged the other bits or the event would read something other than 0x0004. It pulses an event in the same cycle as a clear of that same bit, where a wrong priority loses the event. It also sends out-of-range values to the address port, which a design that truncated the value would wrongly accept. The summary bits are checked after each clear and event, and writes to them are checked to have no effect, so a summary bit that goes stale or that can be written shows up in the readback.

// File: rtl/enet_regs_pkg.sv
package enet_regs_pkg;
  localparam int WORD_W = 16;
  localparam int NUM_REGS = 4;

  // bit positions in the main control/status word
  localparam int B_ERR  = 15;
  localparam int B_BABL = 14;
  localparam int B_CERR = 13;
  localparam int B_MISS = 12;
  localparam int B_MERR = 11;
  localparam int B_RINT = 10;
  localparam int B_TINT = 9;
  localparam int B_IDON = 8;
  localparam int B_INTR = 7;
  localparam int B_INEA = 6;
  localparam int B_RXON = 5;
  localparam int B_TXON = 4;
  localparam int B_STOP = 2;
  localparam int B_STRT = 1;
  localparam int B_INIT = 0;

  localparam logic [WORD_W-1:0] CLR_MASK  = 16'h7F00;
  localparam logic [WORD_W-1:0] STOP_WORD = 16'h0004;

  typedef enum logic {PORT_DATA = 1'b0, PORT_ADDR = 1'b1} port_e;
endpackage

// File: rtl/enet_sel_reg.sv
module enet_sel_reg #(
  parameter int DW    = 16,
  parameter int NREG  = 4,
  localparam int SW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [SW-1:0] sel
);
  logic in_range;
  assign in_range = (wdata < DW'(NREG));

  always_ff @(posedge clk) begin
    if (!rst_n)              sel <= '0;
    else if (wr && in_range) sel <= wdata[SW-1:0];
  end

  // R2: out-of-range selections are dropped
  a_r2_reject_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !in_range) |=> $stable(sel));
  a_r2_accept_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && in_range) |=> (DW'(sel) == $past(wdata)));
endmodule

// File: rtl/enet_ctl_csr.sv
module enet_ctl_csr
  import enet_regs_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rx_evt,
  input  logic          tx_evt,
  output logic [DW-1:0] csr
);
  logic [DW-1:0] nxt;
  logic          stop_wr;

  assign stop_wr = wr && wdata[B_STOP];

  always_comb begin
    nxt = csr;
    if (wr) begin
      if (wdata[B_STOP]) begin
        nxt = STOP_WORD;
      end else begin
        nxt = csr & ~(wdata & CLR_MASK);
        nxt[B_INEA] = wdata[B_INEA];
        if (wdata[B_INIT]) begin
          nxt[B_INIT] = 1'b1;
          nxt[B_IDON] = 1'b1;
          nxt[B_STOP] = 1'b0;
        end else if (wdata[B_STRT]) begin
          nxt[B_STRT] = 1'b1;
          nxt[B_RXON] = 1'b1;
          nxt[B_TXON] = 1'b1;
          nxt[B_STOP] = 1'b0;
        end
      end
    end
    if (!stop_wr) begin
      if (rx_evt) nxt[B_RINT] = 1'b1;
      if (tx_evt) nxt[B_TINT] = 1'b1;
    end
    nxt[3]      = 1'b0;
    nxt[B_ERR]  = |nxt[B_BABL:B_MERR];
    nxt[B_INTR] = |nxt[B_BABL:B_IDON];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) csr <= STOP_WORD;
    else        csr <= nxt;
  end

  a_r3_stop_exact: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> (csr == STOP_WORD));
  a_r4_clear_rint: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata[B_STOP] && wdata[B_RINT] && !rx_evt) |=> !csr[B_RINT]);
  a_r5_err_summary: assert property (@(posedge clk) disable iff (!rst_n)
    csr[B_ERR] == (|csr[B_BABL:B_MERR]));
  a_r5_intr_summary: assert property (@(posedge clk) disable iff (!rst_n)
    csr[B_INTR] == (|csr[B_BABL:B_IDON]));
  a_r7_init_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata[B_STOP] && wdata[B_INIT]) |=>
      (csr[B_INIT] && csr[B_IDON] && !csr[B_STOP]));
  a_r8_rx_event: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && !stop_wr) |=> (csr[B_RINT] && csr[B_INTR]));
  a_r8_tx_event: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt && !stop_wr) |=> (csr[B_TINT] && csr[B_INTR]));
endmodule

// File: rtl/enet_aux_regs.sv
module enet_aux_regs #(
  parameter int DW     = 16,
  parameter int HALVES = 2,
  parameter int MODE_W = 3,
  localparam int PW    = DW * HALVES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALVES-1:0] wr_half,
  input  logic              wr_mode,
  input  logic [DW-1:0]     wdata,
  output logic [PW-1:0]     ptr,
  output logic [MODE_W-1:0] mode
);
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n)          ptr[h*DW +: DW] <= '0;
      else if (wr_half[h]) ptr[h*DW +: DW] <= wdata;
    end
    // R10: each half takes the written word
    a_r10_half_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_half[h] |=> (ptr[h*DW +: DW] == $past(wdata)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mode <= '0;
    else if (wr_mode) mode <= wdata[MODE_W-1:0];
  end

  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(mode));
endmodule

// File: rtl/enet_regfile.sv
module enet_regfile
  import enet_regs_pkg::*;
#(
  parameter int DW     = WORD_W,
  parameter int NREG   = NUM_REGS,
  parameter int MODE_W = 3,
  localparam int SW    = $clog2(NREG),
  localparam int PW    = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_port,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              rx_done,
  input  logic              tx_done,
  output logic              irq,
  output logic [PW-1:0]     init_ptr,
  output logic [MODE_W-1:0] bus_mode
);
  logic          wr_addr, wr_data;
  logic [SW-1:0] sel;
  logic [NREG-1:0] wr_reg;
  logic [DW-1:0] csr;
  logic [DW-1:0] rd_word [NREG];

  assign wr_addr = bus_en && bus_we && (bus_port == PORT_ADDR);
  assign wr_data = bus_en && bus_we && (bus_port == PORT_DATA);

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign wr_reg[i] = wr_data && (sel == SW'(i));
  end

  enet_sel_reg #(.DW(DW), .NREG(NREG)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr(wr_addr), .wdata(bus_wdata), .sel(sel)
  );

  enet_ctl_csr #(.DW(DW)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr(wr_reg[0]), .wdata(bus_wdata),
    .rx_evt(rx_done), .tx_evt(tx_done), .csr(csr)
  );

  enet_aux_regs #(.DW(DW), .HALVES(2), .MODE_W(MODE_W)) u_aux (
    .clk(clk), .rst_n(rst_n), .wr_half(wr_reg[2:1]), .wr_mode(wr_reg[3]),
    .wdata(bus_wdata), .ptr(init_ptr), .mode(bus_mode)
  );

  assign rd_word[0] = csr;
  assign rd_word[1] = init_ptr[DW-1:0];
  assign rd_word[2] = init_ptr[PW-1:DW];
  assign rd_word[3] = {{(DW-MODE_W){1'b0}}, bus_mode};
  for (genvar j = 4; j < NREG; j++) begin : g_pad
    assign rd_word[j] = '0;
  end

  assign bus_rdata = (bus_port == PORT_ADDR) ? {{(DW-SW){1'b0}}, sel}
                                             : rd_word[sel];
  assign irq = csr[B_INTR] & csr[B_INEA];

  // R9: interrupt follows the stored summary and enable bits one cycle later
  a_r9_irq_track: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reg[0] && !bus_wdata[B_STOP] && !bus_wdata[B_INEA]) |=> !irq);
endmodule

// File: tb/enet_regfile_test.sv
module enet_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_en = 0, bus_we = 0, bus_port = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        rx_done = 0, tx_done = 0;
  logic        irq;
  logic [31:0] init_ptr;
  logic [2:0]  bus_mode;
  int total = 0, bad = 0;

  enet_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_done(rx_done), .tx_done(tx_done), .irq(irq),
    .init_ptr(init_ptr), .bus_mode(bus_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_ev(input logic port, input logic [15:0] v, input logic rx, input logic tx);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_port = port; bus_wdata = v;
    rx_done = rx; tx_done = tx;
    @(negedge clk);
    bus_en = 0; bus_we = 0; rx_done = 0; tx_done = 0;
  endtask

  task automatic wr(input logic port, input logic [15:0] v);
    wr_ev(port, v, 0, 0);
  endtask

  task automatic pulse(input logic rx, input logic tx);
    @(negedge clk);
    rx_done = rx; tx_done = tx;
    @(negedge clk);
    rx_done = 0; tx_done = 0;
  endtask

  task automatic rd(input logic port, output logic [15:0] v);
    bus_port = port; bus_en = 1; bus_we = 0;
    #1 v = bus_rdata;
    bus_en = 0;
  endtask

  task automatic rd_reg(input logic [1:0] n, output logic [15:0] v);
    wr(1, {14'd0, n});
    rd(0, v);
  endtask

  task automatic wr_reg(input logic [1:0] n, input logic [15:0] v);
    wr(1, {14'd0, n});
    wr(0, v);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(1, v);             check("R1 sel after reset", v, 0);
    rd(0, v);             check("R1 csr after reset", v, 16'h0004);
    check("R1 ptr", init_ptr, 0);
    check("R1 mode", bus_mode, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_commands;
    logic [15:0] v;
    wr_reg(0, 16'h0001); rd_reg(0, v); check("R7 init", v, 16'h0181);
    check("R9 irq disabled", irq, 0);
    wr_reg(0, 16'h0040); rd_reg(0, v); check("R6 enable set", v, 16'h01C1);
    check("R9 irq on", irq, 1);
    wr_reg(0, 16'h0140); rd_reg(0, v); check("R4 clear idon", v, 16'h0041);
    check("R9 irq off after clear", irq, 0);
    wr_reg(0, 16'h0042); rd_reg(0, v); check("R7 start", v, 16'h0073);
    wr_reg(0, 16'h7F47); rd_reg(0, v); check("R3 stop exact", v, 16'h0004);
    wr_reg(0, 16'h0003); rd_reg(0, v); check("R7 init beats start", v, 16'h0181);
    wr_reg(0, 16'h0004); rd_reg(0, v); check("R3 stop again", v, 16'h0004);
  endtask

  task automatic t_events;
    logic [15:0] v;
    wr(1, 0);
    pulse(1, 0); rd(0, v); check("R8 rx event", v, 16'h0484);
    pulse(0, 1); rd(0, v); check("R8 tx event", v, 16'h0684);
    wr(0, 16'h0400); rd(0, v); check("R4 clear rint", v, 16'h0284);
    wr(0, 16'h0200); rd(0, v); check("R5 intr drops", v, 16'h0004);
    wr_ev(0, 16'h0440, 1, 0); rd(0, v); check("R8 event beats clear", v, 16'h04C4);
    check("R9 irq from event", irq, 1);
    wr_ev(0, 16'h0004, 1, 0); rd(0, v); check("R3 stop beats event", v, 16'h0004);
    check("R9 irq after stop", irq, 0);
  endtask

  task automatic t_ignored;
    logic [15:0] v;
    wr(0, 16'h8088); rd(0, v); check("R5 summary bits not writable", v, 16'h0004);
    wr(0, 16'h0000); rd(0, v); check("R4 zero write keeps", v, 16'h0004);
  endtask

  task automatic t_addr;
    logic [15:0] v;
    wr(1, 2);      rd(1, v); check("R2 select 2", v, 16'h0002);
    wr(1, 5);      rd(1, v); check("R2 reject 5", v, 16'h0002);
    wr(1, 16'hFFFF); rd(1, v); check("R2 reject ffff", v, 16'h0002);
    wr(1, 16'h0004); rd(1, v); check("R2 reject 4", v, 16'h0002);
    wr(1, 3);      rd(1, v); check("R2 select 3", v, 16'h0003);
  endtask

  task automatic t_aux;
    logic [15:0] v;
    wr_reg(1, 16'h1234);
    wr_reg(2, 16'hABCD);
    check("R10 pointer", init_ptr, 32'hABCD1234);
    rd(0, v); check("R10 read high half", v, 16'hABCD);
    rd_reg(1, v); check("R10 read low half", v, 16'h1234);
    wr_reg(3, 16'hFFFF);
    rd(0, v); check("R10 mode readback", v, 16'h0007);
    check("R10 mode pins", bus_mode, 3'd7);
    rd_reg(0, v); check("R10 csr untouched", v, 16'h0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_commands;
    t_events;
    t_ignored;
    t_addr;
    t_aux;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule